// File: doc/BRIEF.md
# Quad-IO Serial Flash Command Responder

This block is the slave-side command front end of a serial flash device running with four data lines. While chip select is low it gathers an 8-bit opcode, four bits per serial clock, on a split data pad (input nibble, output nibble, output enable). It keeps three 8-bit configuration registers: a non-volatile one, a volatile one and an enhanced volatile one. It also keeps a deep power-down flag. It answers the identification read and the two volatile register reads by driving nibbles back on the same four lines.

Register writes, power-down entry and power-down release take effect when chip select rises. They take effect only if the exact number of nibbles for that command was clocked. A busy input marks an erase or program cycle in progress. An opcode that completes while busy is high is dropped, with no reply and no state change. While powered down, the block listens only for the release opcode.

The identification reply is the 3-byte manufacturer and device code and nothing longer. The chip-select rising edge ends a session at once. It releases the data pins and returns the block to standby, ready for the next opcode.

Top module: `qio_cmd_responder`

## Requirements
- R1: An opcode is taken on the first two rising `sck` edges after `cs_n` falls, high nibble first, with `dq_i[3]` as the most significant bit of each nibble; `dq_oe` stays low until both opcode nibbles are in.
- R2: Opcode AFh returns `ID_CODE` as six nibbles: the manufacturer byte (bits 23:16) first, then the two device bytes, most significant nibble first. Each nibble appears on the falling `sck` edge. The first appears on the falling edge right after the second opcode nibble, and the sequence repeats from the first nibble after the sixth, so no longer code is ever returned.
- R3: Opcode 85h returns the volatile register and 65h the enhanced volatile register, as two nibbles (high, then low) on falling edges, repeating while clocked.
- R4: Opcodes 81h (volatile), 61h (enhanced volatile) and B1h (non-volatile) load the data byte that follows (high nibble first). The load happens when `cs_n` rises, and only if exactly two data nibbles followed the opcode; otherwise the register keeps its value.
- R5: Opcode B9h sets `deep_pd` and ABh clears it, each on the `cs_n` rising edge and only if no nibble followed the opcode.
- R6: While `deep_pd` is set, every opcode other than ABh is ignored: no pin is driven and no register or flag changes.
- R7: An opcode whose second nibble is clocked while `busy` is high is ignored: no reply, no register change, no power-state change.
- R8: `dq_oe` is low whenever `cs_n` is high. It is low for opcodes other than AFh, 85h and 65h. A `cs_n` rise in the middle of a reply drops `dq_oe` at once.
- R9: After reset `nvcfg_q`=FFh, `vcfg_q`=FBh, `evcfg_q`=DFh, `deep_pd`=0 and `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| dq_i | input | 4 | Data pad input nibble |
| dq_o | output | 4 | Data pad output nibble |
| dq_oe | output | 1 | Data pad output enable |
| busy | input | 1 | Erase or program cycle in progress |
| nvcfg_q | output | 8 | Non-volatile configuration register |
| vcfg_q | output | 8 | Volatile configuration register |
| evcfg_q | output | 8 | Enhanced volatile configuration register |
| deep_pd | output | 1 | Deep power-down state |

## Verification
On every clock the assertions check that nothing is driven before the opcode is complete or for a dropped command. They also check that the registers only change on a `cs_n` edge that closes a correctly sized write, that power-down holds unless a clean release arrives, and that the identification sequence wraps after its low nibble. The nibble values and their order, the full sweep of all 256 opcodes, the effect of each write on the register read back, and the behaviour under busy or in power-down are shown only by the bench's scenarios.

// File: rtl/qio_cmd_responder.sv
module qio_cmd_responder #(
  parameter logic [23:0] ID_CODE   = 24'hC25A17,
  parameter logic [7:0]  NVCFG_RST = 8'hFF,
  parameter logic [7:0]  VCFG_RST  = 8'hFB,
  parameter logic [7:0]  EVCFG_RST = 8'hDF,
  parameter int          CNT_W     = 4
) (
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [3:0] dq_i,
  output logic [3:0] dq_o,
  output logic       dq_oe,
  input  logic       busy,
  output logic [7:0] nvcfg_q,
  output logic [7:0] vcfg_q,
  output logic [7:0] evcfg_q,
  output logic       deep_pd
);
  localparam logic [7:0] OP_ID    = 8'hAF;
  localparam logic [7:0] OP_RDV   = 8'h85;
  localparam logic [7:0] OP_WRV   = 8'h81;
  localparam logic [7:0] OP_RDEV  = 8'h65;
  localparam logic [7:0] OP_WREV  = 8'h61;
  localparam logic [7:0] OP_WRNV  = 8'hB1;
  localparam logic [7:0] OP_PDN   = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(4);

  logic             ses_rst;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       op;
  logic [7:0]       wbyte;
  logic             live;
  logic [2:0]       idx;
  logic             oe_r;
  logic             is_rd;
  logic [2:0]       rlast;
  logic [23:0]      rword;
  logic [4:0]       base;
  logic [3:0]       nib;

  assign ses_rst = cs_n | ~rst_n;

  // rising edge: opcode and data byte capture
  always_ff @(posedge sck or posedge ses_rst) begin
    if (ses_rst) begin
      cnt   <= '0;
      op    <= '0;
      wbyte <= '0;
      live  <= 1'b0;
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      case (cnt)
        CNT_W'(0): op[7:4] <= dq_i;
        CNT_W'(1): begin
          op[3:0] <= dq_i;
          live    <= !busy && (!deep_pd || {op[7:4], dq_i} == OP_WAKE);
        end
        CNT_W'(2): wbyte[7:4] <= dq_i;
        CNT_W'(3): wbyte[3:0] <= dq_i;
        default: ;
      endcase
    end
  end

  // reply selection
  always_comb begin
    is_rd = (op == OP_ID) || (op == OP_RDV) || (op == OP_RDEV);
    rlast = (op == OP_ID) ? 3'd5 : 3'd1;
    case (op)
      OP_ID:   rword = ID_CODE;
      OP_RDV:  rword = {16'h0, vcfg_q};
      default: rword = {16'h0, evcfg_q};
    endcase
    base = {rlast - idx, 2'b00};
    nib  = rword[base +: 4];
  end

  // falling edge: nibble output
  always_ff @(negedge sck or posedge ses_rst) begin
    if (ses_rst) begin
      idx  <= '0;
      oe_r <= 1'b0;
      dq_o <= '0;
    end else if (cnt >= CNT_OP && live && is_rd) begin
      dq_o <= nib;
      oe_r <= 1'b1;
      idx  <= (idx == rlast) ? 3'd0 : idx + 3'd1;
    end
  end

  assign dq_oe = oe_r & ~cs_n;

  // chip-select rise: commit writes and power state
  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      nvcfg_q <= NVCFG_RST;
      vcfg_q  <= VCFG_RST;
      evcfg_q <= EVCFG_RST;
      deep_pd <= 1'b0;
    end else if (live) begin
      if (cnt == CNT_BYTE) begin
        case (op)
          OP_WRV:  vcfg_q  <= wbyte;
          OP_WREV: evcfg_q <= wbyte;
          OP_WRNV: nvcfg_q <= wbyte;
          default: ;
        endcase
      end
      if (cnt == CNT_OP) begin
        if (op == OP_PDN)  deep_pd <= 1'b1;
        if (op == OP_WAKE) deep_pd <= 1'b0;
      end
    end
  end

  AST_NO_DRIVE_IN_OPCODE: assert property (@(posedge sck) disable iff (ses_rst)
    (cnt < CNT_OP) |-> !dq_oe); // R1
  AST_DROPPED_SILENT: assert property (@(negedge sck) disable iff (ses_rst)
    (cnt >= CNT_OP && !live) |-> !dq_oe); // R7
  AST_REG_ONLY_ON_BYTE: assert property (@(posedge cs_n) disable iff (!rst_n)
    (cnt != CNT_BYTE) |=> ($stable(vcfg_q) && $stable(evcfg_q) && $stable(nvcfg_q))); // R4
  AST_PD_HOLDS: assert property (@(posedge cs_n) disable iff (!rst_n)
    (deep_pd && !(live && cnt == CNT_OP && op == OP_WAKE)) |=> deep_pd); // R6
  AST_ID_WRAP_LOW: assert property (@(negedge sck) disable iff (ses_rst)
    (dq_oe && op == OP_ID && idx == 3'd0) |-> (dq_o == ID_CODE[3:0])); // R2
endmodule

// File: tb/sim_qio_cmd_responder.sv
`timescale 1ns/1ps
module sim_qio_cmd_responder;
  localparam logic [23:0] ID = 24'hC25A17;
  logic rst_n, sck, cs_n, busy;
  logic [3:0] dq_i;
  logic [3:0] dq_o;
  logic dq_oe, dpd;
  logic [7:0] nv, v, ev;
  logic [7:0] e_nv, e_v, e_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  qio_cmd_responder #(.ID_CODE(ID)) u0 (
    .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe), .busy(busy), .nvcfg_q(nv), .vcfg_q(v), .evcfg_q(ev),
    .deep_pd(dpd));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    #5 sck = 1'b1;
    #10 sck = 1'b0;
    #5;
  endtask

  task automatic nib(input logic [3:0] n);
    dq_i = n;
    tick();
  endtask

  task automatic start(input logic [7:0] op);
    cs_n = 1'b0;
    #10;
    nib(op[7:4]);
    nib(op[3:0]);
  endtask

  task automatic stop();
    cs_n = 1'b1;
    dq_i = 4'h0;
    #20;
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] d);
    start(op);
    nib(d[7:4]);
    nib(d[3:0]);
    stop();
  endtask

  task automatic regs(input string tag);
    chk({tag, " vcfg"}, {24'h0, v}, {24'h0, e_v});
    chk({tag, " evcfg"}, {24'h0, ev}, {24'h0, e_ev});
    chk({tag, " nvcfg"}, {24'h0, nv}, {24'h0, e_nv});
  endtask

  task automatic rd(input string tag, input logic [7:0] op, input logic [23:0] w, input int len);
    start(op);
    for (int k = 0; k < 2 * len; k++) begin
      chk({tag, " oe"}, {31'h0, dq_oe}, 32'h1);
      chk({tag, " nibble"}, {28'h0, dq_o}, {28'h0, 4'((w >> (4 * (len - 1 - (k % len)))) & 24'hF)});
      tick();
    end
    stop();
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sck = 0; cs_n = 1; busy = 0; dq_i = 0;
    e_nv = 8'hFF; e_v = 8'hFB; e_ev = 8'hDF;
    #50;
    // R9 reset state
    chk("R9 deep_pd", {31'h0, dpd}, 32'h0);
    chk("R9 dq_oe", {31'h0, dq_oe}, 32'h0);
    regs("R9");
    rst_n = 1;
    #20;

    // R2 identification, including wrap after six nibbles
    rd("R2 id", 8'hAF, ID, 6);
    // R3 register reads of reset values
    rd("R3 vcfg", 8'h85, {16'h0, e_v}, 2);
    rd("R3 evcfg", 8'h65, {16'h0, e_ev}, 2);

    // R1 R8 R4 R5: sweep of every opcode with four extra nibbles
    for (int op = 0; op < 256; op++) begin
      bit rdop;
      rdop = (op == 8'h85) || (op == 8'h65) || (op == 8'hAF);
      start(8'(op));
      for (int k = 0; k < 4; k++) begin
        chk("R8 sweep oe", {31'h0, dq_oe}, {31'h0, rdop});
        tick();
      end
      cs_n = 1'b1;
      #1 chk("R8 oe after cs rise", {31'h0, dq_oe}, 32'h0);
      #19;
      chk("R5 sweep extra nibbles no pd", {31'h0, dpd}, 32'h0);
      regs("R4 sweep oversize write");
    end

    // R1 opcode nibble order: 5Ah is not a read, A5h is not; swapped 58h vs 85h
    start(8'h58);
    chk("R1 swapped nibbles", {31'h0, dq_oe}, 32'h0);
    stop();

    // R4 write sweeps with read-back
    for (int d = 0; d < 256; d++) begin
      wr(8'h81, 8'(d)); e_v = 8'(d);
      regs("R4 wr vcfg");
      rd("R3 vcfg rb", 8'h85, {16'h0, e_v}, 2);
      wr(8'h61, 8'(255 - d)); e_ev = 8'(255 - d);
      regs("R4 wr evcfg");
      rd("R3 evcfg rb", 8'h65, {16'h0, e_ev}, 2);
      wr(8'hB1, 8'(d ^ 8'h3C)); e_nv = 8'(d ^ 8'h3C);
      regs("R4 wr nvcfg");
    end

    // R4 short writes
    start(8'h81); stop(); regs("R4 no data");
    start(8'h81); nib(4'h1); stop(); regs("R4 one nibble");
    start(8'h61); nib(4'h1); nib(4'h2); nib(4'h3); stop(); regs("R4 three nibbles");

    // R8 cs rise mid reply
    start(8'hAF);
    chk("R8 reply on", {31'h0, dq_oe}, 32'h1);
    tick(); tick();
    cs_n = 1'b1;
    #1 chk("R8 mid reply release", {31'h0, dq_oe}, 32'h0);
    #19;

    // R7 busy
    busy = 1'b1;
    start(8'hAF);
    for (int k = 0; k < 3; k++) begin
      chk("R7 busy id silent", {31'h0, dq_oe}, 32'h0);
      tick();
    end
    stop();
    wr(8'h81, 8'h3C); regs("R7 busy write");
    start(8'hB9); stop();
    chk("R7 busy pd", {31'h0, dpd}, 32'h0);
    busy = 1'b0;

    // R5 R6 power-down
    start(8'hB9); stop();
    chk("R5 enter pd", {31'h0, dpd}, 32'h1);
    for (int op = 0; op < 256; op++) begin
      if (op == 8'hAB) continue;
      start(8'(op));
      chk("R6 pd silent", {31'h0, dq_oe}, 32'h0);
      nib(4'h5);
      chk("R6 pd silent2", {31'h0, dq_oe}, 32'h0);
      nib(4'hA);
      stop();
      chk("R6 pd kept", {31'h0, dpd}, 32'h1);
      regs("R6 pd regs");
    end
    start(8'hAB); nib(4'h0); stop();
    chk("R5 release with extra nibble", {31'h0, dpd}, 32'h1);
    start(8'hAB); stop();
    chk("R5 release", {31'h0, dpd}, 32'h0);
    rd("R2 id after wake", 8'hAF, ID, 6);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule